// File: doc/BRIEF.md
# Four-Cell Sorting Mismatch Shaper

This block takes a thermometer count from 0 to 4 and decides which of four unit DAC cells carry it in the next cycle. Each cell has its own fourth-order bandpass loop filter, centred at a quarter of the sample rate. The filter's output is the cell's priority. On every valid code the cells are ranked by priority and the `code` best-ranked cells are selected. The selection vector then drives the four filters. The minimum of the new second-stage outputs is removed from all four as a common offset. This keeps the registers small and leaves the ranking unchanged.

The block is meant to sit at the end of a tree divider, where each leaf hands it a small count. The selection is registered: it appears one cycle after the code, together with a valid flag. Cells that are selected often lose priority, so the mismatch error of the cells is pushed away from fs/4.

Top module: `sort_shaper`

## Requirements
- R1: One cycle after `codeValid` is high, `cellSel` has exactly min(`code`,4) bits set and `selValid` is high.
- R2: Codes 5, 6 and 7 behave exactly like code 4: all four cells are selected and the filters are updated with the same inputs as for code 4.
- R3: A cycle with `codeValid` low gives `selValid` low and `cellSel` = 0 in the next cycle, and it leaves every filter register unchanged.
- R4: The cells with the largest priority are selected first. On equal priority the lower cell index wins. Bit i of `cellSel` is cell i.
- R5: Each cell's filter has two stages. Each stage has the form r[n] = in[n] - r[n-2]. The first stage takes the cell's select bit (0 or 1). The second stage takes the negated first-stage output. The cell's priority is the second-stage output.
- R6: After each update, the minimum of the four new second-stage outputs is subtracted from each of them, so the smallest stored priority is 0.
- R7: Every filter register is 6-bit two's complement and saturates at -32 and +31 instead of wrapping.
- R8: Reset (`rstN` low) clears all filter registers, `cellSel` and `selValid`. The first code after reset therefore selects cells from index 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| codeValid | input | 1 | `code` is valid this cycle |
| code | input | 3 | Number of cells to turn on (0..4; 5..7 behave as 4) |
| cellSel | output | 4 | Registered cell selection, bit i = cell i |
| selValid | output | 1 | `cellSel` carries a selection for the previous code |

## Verification
In one valid cycle the ranking and the filter update with offset removal happen together. The ranking must use the priorities from before the update, while the update depends on the selection the ranking has just produced. The bench provokes this with back-to-back valid codes that arrive while priorities are tied, and with gaps between codes. Every registered selection is judged against an independent model of the filters, stepped one code at a time. An error in the ordering shows up as a wrong cell set on the next code.

// File: rtl/shaper_pkg.sv
package shaper_pkg;
  localparam int CELLS   = 4;
  localparam int STATE_W = 6;
  localparam int CODE_W  = 3;
  localparam int EXT_W   = STATE_W + 3;
  localparam int RANK_W  = $clog2(CELLS + 1);

  localparam logic signed [EXT_W-1:0] EXT_MAX = EXT_W'((1 <<< (STATE_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] EXT_MIN = -EXT_W'(1 <<< (STATE_W - 1));

  typedef struct packed {
    logic              stepEn;
    logic [CODE_W-1:0] count;
  } strobe_t;

  function automatic logic signed [STATE_W-1:0] satState(input logic signed [EXT_W-1:0] v);
    logic signed [EXT_W-1:0] c;
    c = v;
    if (v > EXT_MAX) c = EXT_MAX;
    else if (v < EXT_MIN) c = EXT_MIN;
    return c[STATE_W-1:0];
  endfunction
endpackage

// File: rtl/shaper_ctrl.sv
module shaper_ctrl
  import shaper_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              codeValid,
  input  logic [CODE_W-1:0] code,
  output strobe_t           stb,
  output logic              selValid
);
  localparam logic [CODE_W-1:0] CODE_CAP = CODE_W'(CELLS);

  always_comb begin
    stb.stepEn = codeValid;
    stb.count  = (code > CODE_CAP) ? CODE_CAP : code;
  end

  always_ff @(posedge clk) begin
    if (!rstN) selValid <= 1'b0;
    else       selValid <= codeValid;
  end

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !codeValid |=> !selValid); // R3
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |=> selValid); // R1
endmodule

// File: rtl/shaper_path.sv
module shaper_path
  import shaper_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  output logic [CELLS-1:0] cellSel
);
  logic signed [STATE_W-1:0] r1a [CELLS];
  logic signed [STATE_W-1:0] r1b [CELLS];
  logic signed [STATE_W-1:0] r2a [CELLS];
  logic signed [STATE_W-1:0] r2b [CELLS];

  logic signed [STATE_W-1:0] r1n   [CELLS];
  logic signed [STATE_W-1:0] r2raw [CELLS];
  logic signed [STATE_W-1:0] r2n   [CELLS];
  logic signed [STATE_W-1:0] minRaw;
  logic [CELLS-1:0]          selNext;
  logic [RANK_W-1:0]         rank [CELLS];

  // ranking on current priorities
  always_comb begin
    for (int i = 0; i < CELLS; i++) begin
      rank[i] = '0;
      for (int j = 0; j < CELLS; j++) begin
        if (j != i) begin
          if ((r2a[j] > r2a[i]) || ((r2a[j] == r2a[i]) && (j < i)))
            rank[i] = rank[i] + 1'b1;
        end
      end
      selNext[i] = (RANK_W'(rank[i]) < RANK_W'(stb.count));
    end
  end

  // filter step and common offset removal
  always_comb begin
    for (int i = 0; i < CELLS; i++) begin
      r1n[i]   = satState(EXT_W'(selNext[i]) - EXT_W'(r1b[i]));
      r2raw[i] = satState(-EXT_W'(r1n[i]) - EXT_W'(r2b[i]));
    end
    minRaw = r2raw[0];
    for (int i = 1; i < CELLS; i++)
      if (r2raw[i] < minRaw) minRaw = r2raw[i];
    for (int i = 0; i < CELLS; i++)
      r2n[i] = satState(EXT_W'(r2raw[i]) - EXT_W'(minRaw));
  end

  generate
    for (genvar g = 0; g < CELLS; g++) begin : gCell
      always_ff @(posedge clk) begin
        if (!rstN) begin
          r1a[g] <= '0;
          r1b[g] <= '0;
          r2a[g] <= '0;
          r2b[g] <= '0;
        end else if (stb.stepEn) begin
          r1b[g] <= r1a[g];
          r1a[g] <= r1n[g];
          r2b[g] <= r2a[g];
          r2a[g] <= r2n[g];
        end
      end

      AST_PRIO_NONNEG: assert property (@(posedge clk) disable iff (!rstN)
        r2a[g] >= 0); // R6
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        !stb.stepEn |=> ($stable(r1a[g]) && $stable(r2a[g]) && $stable(r1b[g]) && $stable(r2b[g]))); // R3
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)            cellSel <= '0;
    else if (stb.stepEn)  cellSel <= selNext;
    else                  cellSel <= '0;
  end

  logic anyZero;
  always_comb begin
    anyZero = 1'b0;
    for (int i = 0; i < CELLS; i++)
      if (r2a[i] == 0) anyZero = 1'b1;
  end

  AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepEn |=> anyZero); // R6
  AST_SEL_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepEn |=> ($countones(cellSel) == int'($past(stb.count)))); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !stb.stepEn |=> (cellSel == '0)); // R3
endmodule

// File: rtl/sort_shaper.sv
module sort_shaper
  import shaper_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             codeValid,
  input  logic [2:0]       code,
  output logic [3:0]       cellSel,
  output logic             selValid
);
  strobe_t stb;

  shaper_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .codeValid(codeValid),
    .code     (code),
    .stb      (stb),
    .selValid (selValid)
  );

  shaper_path uPath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .cellSel(cellSel)
  );
endmodule

// File: tb/sort_shaper_test.sv
module sort_shaper_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       codeValid = 1'b0;
  logic [2:0] code = '0;
  logic [3:0] cellSel;
  logic       selValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  int m1a[4], m1b[4], m2a[4], m2b[4];

  always #2 clk = ~clk;

  sort_shaper uut (
    .clk(clk), .rstN(rstN), .codeValid(codeValid), .code(code),
    .cellSel(cellSel), .selValid(selValid)
  );

  function automatic int clampS(input int v);
    if (v > 31) return 31;
    if (v < -32) return -32;
    return v;
  endfunction

  function automatic logic [3:0] modelSel(input int cnt);
    logic [3:0] s;
    for (int i = 0; i < 4; i++) begin
      int rk = 0;
      for (int j = 0; j < 4; j++)
        if (j != i && (m2a[j] > m2a[i] || (m2a[j] == m2a[i] && j < i))) rk++;
      s[i] = (rk < cnt);
    end
    return s;
  endfunction

  task automatic modelStep(input logic [3:0] s);
    int n1[4], raw[4];
    int mn;
    for (int i = 0; i < 4; i++) begin
      n1[i]  = clampS(int'(s[i]) - m1b[i]);
      raw[i] = clampS(-n1[i] - m2b[i]);
    end
    mn = raw[0];
    for (int i = 1; i < 4; i++) if (raw[i] < mn) mn = raw[i];
    for (int i = 0; i < 4; i++) begin
      m1b[i] = m1a[i]; m1a[i] = n1[i];
      m2b[i] = m2a[i]; m2a[i] = clampS(raw[i] - mn);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < 4; i++) begin m1a[i] = 0; m1b[i] = 0; m2a[i] = 0; m2b[i] = 0; end
  endtask

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // at a negedge: drive, wait one cycle, check against model
  task automatic step(input bit v, input int c, input string req);
    logic [3:0] expSel;
    int cnt;
    cnt = (c > 4) ? 4 : c;
    codeValid = v;
    code = 3'(c);
    expSel = v ? modelSel(cnt) : 4'b0000;
    @(negedge clk);
    check(req, {selValid, cellSel}, {v, expSel});
    if (v) begin
      nChecks++;
      if ($countones(cellSel) != cnt) begin
        nFails++;
        $display("FAIL R1: actual count %0d expected %0d", $countones(cellSel), cnt);
      end
      modelStep(expSel);
    end
  endtask

  task automatic tReset();
    rstN = 1'b0; codeValid = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 reset", {selValid, cellSel}, 5'b0);
    rstN = 1'b1;
    modelClear();
  endtask

  task automatic tFirstCode();
    step(1, 2, "R8 first after reset");
    check("R4 tie picks low index", {1'b0, cellSel}, 5'b00011);
  endtask

  task automatic tRotate();
    for (int k = 0; k < 12; k++) step(1, 1, "R4 R5 single cell rotation");
  endtask

  task automatic tMixed();
    int seq[16] = '{3, 0, 4, 1, 2, 2, 3, 1, 0, 4, 2, 1, 3, 3, 2, 0};
    for (int k = 0; k < 16; k++) step(1, seq[k], "R5 R6 mixed codes");
  endtask

  task automatic tGaps();
    step(1, 1, "R1 before gap");
    step(0, 3, "R3 idle output");
    step(0, 1, "R3 idle output");
    step(1, 1, "R3 state held through gap");
    step(0, 0, "R3 idle output");
    step(1, 2, "R3 state held through gap");
  endtask

  task automatic tOverRange();
    step(1, 5, "R2 code 5");
    step(1, 7, "R2 code 7");
    step(1, 6, "R2 code 6");
    step(1, 1, "R2 state after over-range");
  endtask

  task automatic tLong();
    for (int k = 0; k < 200; k++) step(1, (k * 7 + k / 3) % 5, "R7 long run");
    for (int k = 0; k < 40; k++) step(1, (k % 2 == 0) ? 1 : 3, "R7 alternating");
  endtask

  initial begin
    #400000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    modelClear();
    tReset();
    tFirstCode();
    tRotate();
    tMixed();
    tGaps();
    tOverRange();
    tLong();
    tReset();
    step(1, 1, "R8 reset restarts at cell 0");
    check("R8 cell 0 after reset", {1'b0, cellSel}, 5'b00001);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule